// File: doc/BRIEF.md
# Instruction Cycle Controller

This block is the control unit of a small accumulator machine. It walks each instruction through a fixed series of subcycles: fetch, an optional indirect step, execute, and interrupt entry when one is due. Along the way it moves words between a program counter (PC), a memory address register (MAR), a memory buffer register (MBR), an instruction register (IR) and an accumulator.

All memory traffic goes through one single-port memory. The block raises a request, optionally with a write strobe, and holds it until the memory answers with a ready pulse, so the memory may take any number of cycles.

The data operations are only a placeholder set: load, add and store. Interrupt entry reuses the MAR/MBR path. The address of the next instruction is written to a fixed save word, and fetching then resumes at a fixed handler address.

Top module: `icyc_ctrl`

## Requirements
- R1: While reset is low, pc_o is RESET_PC (0), acc_o is 0, ie_o is 0, halted_o is 0 and mem_req is 0.
- R2: Instruction fetch:
  - After reset, the first memory access is a read at RESET_PC.
  - Each fetch reads the word at the current PC.
  - pc_o rises by one in the cycle after the fetch address is taken, before the read returns.
- R3: A request keeps mem_addr, mem_we and mem_wdata unchanged until mem_ready is seen. The block works with a ready in the first request cycle or any number of cycles later. mem_we is never high without mem_req.
- R4: Instruction word layout: bits [15:13] are the opcode, bit 12 is the indirect flag and bits [11:0] are the address field. When bit 12 is set, the block first reads the word at the address field. The low 12 bits of the word returned are the effective address.
- R5: Data operations, where M[ea] is the word at the effective address:
  - Opcode 1 loads M[ea] into the accumulator.
  - Opcode 2 adds M[ea] to the accumulator, modulo 2^16.
  - Opcode 3 writes the accumulator to M[ea].
- R6: Opcode 4 loads the effective address into the PC, and the next fetch comes from there.
- R7: Control opcodes:
  - Opcode 5 sets the interrupt enable.
  - Opcode 6 clears the interrupt enable.
  - Opcode 0 does nothing.
  - Opcode 7 halts: halted_o goes high and no further memory request is made until reset.
- R8: An interrupt request is taken only when irq and the interrupt enable are both high at the end of an instruction's execute subcycle. With the enable clear, irq has no effect: no save write occurs and execution continues in order.
- R9: On interrupt entry, the block does three things:
  - It writes the address of the next instruction, zero-extended, to SAVE_ADDR.
  - It fetches next from VEC_ADDR.
  - It clears the interrupt enable, so a still-active irq does not enter again.
- R10: An irq that is high during fetch, decode or operand access, but low again at the end of execute, is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request level |
| mem_rdata | input | 16 | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Memory completes the current request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 12 | Request address (MAR) |
| mem_wdata | output | 16 | Write data (MBR) |
| acc_o | output | 16 | Accumulator |
| pc_o | output | 12 | Program counter |
| ie_o | output | 1 | Interrupt enable |
| halted_o | output | 1 | Halt instruction reached |

## Verification
The hardest case to reach is an interrupt request that is present while an instruction is in flight but gone at its end. Showing that such a request is not taken needs irq to rise and fall between the instruction's fetch and its end-of-execute point.

The bench finds those points from the ports alone. It watches mem_addr for the fetch of the target instruction and raises irq there. It drops irq when that instruction's operand read appears. The memory latency is set to three cycles so that the operand read is still open when irq falls.

A second program holds irq high from reset. The first end-of-execute then meets a clear enable, and the one after the enable opcode meets a set one. This covers both the ignored request and the entry, and afterwards shows that the still-high irq does not re-enter.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  localparam int OP_W = 3;

  typedef enum logic [3:0] {
    ST_FETCH_A,
    ST_FETCH_R,
    ST_DECODE,
    ST_IND_R,
    ST_EXEC,
    ST_OPND_R,
    ST_OPND_W,
    ST_CHECK,
    ST_INT_W,
    ST_HALT
  } cyc_state_e;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_ADD   = 3'd2,
    OP_STORE = 3'd3,
    OP_JUMP  = 3'd4,
    OP_IEN   = 3'd5,
    OP_IDIS  = 3'd6,
    OP_HALT  = 3'd7
  } opcode_e;

  // register-transfer controls issued by the sequencer each cycle
  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_mbr;
    logic mar_from_save;
    logic mbr_from_mem;
    logic mbr_from_acc;
    logic mbr_from_pc;
    logic ir_load;
    logic pc_inc;
    logic pc_from_mbr;
    logic pc_from_vec;
    logic acc_load;
    logic acc_add;
    logic ie_set;
    logic ie_clr;
  } xfer_t;

  function automatic logic state_uses_mem(cyc_state_e s);
    return (s == ST_FETCH_R) || (s == ST_IND_R) || (s == ST_OPND_R) ||
           (s == ST_OPND_W)  || (s == ST_INT_W);
  endfunction

  function automatic logic state_writes_mem(cyc_state_e s);
    return (s == ST_OPND_W) || (s == ST_INT_W);
  endfunction

endpackage

// File: rtl/icyc_fsm.sv
module icyc_fsm
  import icyc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq,
  input  logic             ie,
  input  logic             mem_ready,
  input  logic             mbr_ind,
  input  logic [OP_W-1:0]  ir_op,
  output cyc_state_e       state,
  output xfer_t            xfer,
  output logic             int_entry,
  output logic             fetch_issue,
  output logic             halted
);

  cyc_state_e nxt;
  opcode_e    op;

  assign op = opcode_e'(ir_op);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_FETCH_A;
    else        state <= nxt;
  end

  always_comb begin
    xfer = '0;
    nxt  = state;
    case (state)
      ST_FETCH_A: begin
        xfer.mar_from_pc = 1'b1;
        xfer.pc_inc      = 1'b1;
        nxt              = ST_FETCH_R;
      end
      ST_FETCH_R: begin
        if (mem_ready) begin
          xfer.mbr_from_mem = 1'b1;
          nxt               = ST_DECODE;
        end
      end
      ST_DECODE: begin
        xfer.ir_load = 1'b1;
        if (mbr_ind) begin
          xfer.mar_from_mbr = 1'b1;
          nxt               = ST_IND_R;
        end else begin
          nxt = ST_EXEC;
        end
      end
      ST_IND_R: begin
        if (mem_ready) begin
          xfer.mbr_from_mem = 1'b1;
          nxt               = ST_EXEC;
        end
      end
      ST_EXEC: begin
        case (op)
          OP_LOAD, OP_ADD: begin
            xfer.mar_from_mbr = 1'b1;
            nxt               = ST_OPND_R;
          end
          OP_STORE: begin
            xfer.mar_from_mbr = 1'b1;
            xfer.mbr_from_acc = 1'b1;
            nxt               = ST_OPND_W;
          end
          OP_JUMP: begin
            xfer.pc_from_mbr = 1'b1;
            nxt              = ST_CHECK;
          end
          OP_IEN: begin
            xfer.ie_set = 1'b1;
            nxt         = ST_CHECK;
          end
          OP_IDIS: begin
            xfer.ie_clr = 1'b1;
            nxt         = ST_CHECK;
          end
          OP_HALT: nxt = ST_HALT;
          default: nxt = ST_CHECK;
        endcase
      end
      ST_OPND_R: begin
        if (mem_ready) begin
          xfer.acc_load = (op == OP_LOAD);
          xfer.acc_add  = (op != OP_LOAD);
          nxt           = ST_CHECK;
        end
      end
      ST_OPND_W: begin
        if (mem_ready) nxt = ST_CHECK;
      end
      ST_CHECK: begin
        if (irq && ie) begin
          xfer.mbr_from_pc   = 1'b1;
          xfer.mar_from_save = 1'b1;
          xfer.ie_clr        = 1'b1;
          nxt                = ST_INT_W;
        end else begin
          nxt = ST_FETCH_A;
        end
      end
      ST_INT_W: begin
        if (mem_ready) begin
          xfer.pc_from_vec = 1'b1;
          nxt              = ST_FETCH_A;
        end
      end
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_FETCH_A;
    endcase
  end

  assign int_entry   = (state == ST_CHECK) && (nxt == ST_INT_W);
  assign fetch_issue = (state == ST_FETCH_A);
  assign halted      = (state == ST_HALT);

endmodule

// File: rtl/icyc_regs.sv
module icyc_regs
  import icyc_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h0F0,
  parameter logic [ADDR_W-1:0] VEC_ADDR  = 12'h080,
  parameter logic [ADDR_W-1:0] RESET_PC  = 12'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xfer_t             xfer,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [OP_W-1:0]   ir_op,
  output logic              mbr_ind,
  output logic [DATA_W-1:0] acc,
  output logic              ie
);

  localparam int IND_BIT = DATA_W - OP_W - 1;
  localparam int PAD_W   = DATA_W - ADDR_W;

  function automatic logic [ADDR_W-1:0] pc_next(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] acc_sum(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_field(input logic [DATA_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] widen_pc(input logic [ADDR_W-1:0] p);
    return {{PAD_W{1'b0}}, p};
  endfunction

  assign mbr_ind = mbr[IND_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc    <= RESET_PC;
      mar   <= '0;
      mbr   <= '0;
      ir_op <= '0;
      acc   <= '0;
      ie    <= 1'b0;
    end else begin
      if (xfer.mar_from_pc)        mar <= pc;
      else if (xfer.mar_from_mbr)  mar <= addr_field(mbr);
      else if (xfer.mar_from_save) mar <= SAVE_ADDR;

      if (xfer.mbr_from_mem)      mbr <= mem_rdata;
      else if (xfer.mbr_from_acc) mbr <= acc;
      else if (xfer.mbr_from_pc)  mbr <= widen_pc(pc);

      if (xfer.ir_load) ir_op <= mbr[DATA_W-1 -: OP_W];

      if (xfer.pc_inc)           pc <= pc_next(pc);
      else if (xfer.pc_from_mbr) pc <= addr_field(mbr);
      else if (xfer.pc_from_vec) pc <= VEC_ADDR;

      if (xfer.acc_load)     acc <= mem_rdata;
      else if (xfer.acc_add) acc <= acc_sum(acc, mem_rdata);

      if (xfer.ie_set)      ie <= 1'b1;
      else if (xfer.ie_clr) ie <= 1'b0;
    end
  end

endmodule

// File: rtl/icyc_memif.sv
module icyc_memif
  import icyc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  cyc_state_e        state,
  input  logic [ADDR_W-1:0] mar,
  input  logic [DATA_W-1:0] mbr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  assign mem_req   = state_uses_mem(state);
  assign mem_we    = state_writes_mem(state);
  assign mem_addr  = mar;
  assign mem_wdata = mbr;

endmodule

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
  import icyc_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h0F0,
  parameter logic [ADDR_W-1:0] VEC_ADDR  = 12'h080,
  parameter logic [ADDR_W-1:0] RESET_PC  = 12'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              ie_o,
  output logic              halted_o
);

  cyc_state_e        state;
  xfer_t             xfer;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;
  logic [OP_W-1:0]   ir_op;
  logic              mbr_ind;
  logic [DATA_W-1:0] acc;
  logic              ie;
  logic              int_entry;
  logic              fetch_issue;
  logic              halted;

  icyc_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq         (irq),
    .ie          (ie),
    .mem_ready   (mem_ready),
    .mbr_ind     (mbr_ind),
    .ir_op       (ir_op),
    .state       (state),
    .xfer        (xfer),
    .int_entry   (int_entry),
    .fetch_issue (fetch_issue),
    .halted      (halted)
  );

  icyc_regs #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .SAVE_ADDR (SAVE_ADDR),
    .VEC_ADDR  (VEC_ADDR),
    .RESET_PC  (RESET_PC)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer      (xfer),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .mar       (mar),
    .mbr       (mbr),
    .ir_op     (ir_op),
    .mbr_ind   (mbr_ind),
    .acc       (acc),
    .ie        (ie)
  );

  icyc_memif #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_memif (
    .state     (state),
    .mar       (mar),
    .mbr       (mbr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assign acc_o    = acc;
  assign pc_o     = pc;
  assign ie_o     = ie;
  assign halted_o = halted;

endmodule

// File: rtl/icyc_chk.sv
module icyc_chk #(
  parameter int                DATA_W    = 16,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h0F0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] pc_o,
  input logic              ie_o,
  input logic              halted_o,
  input logic              int_entry,
  input logic              fetch_issue
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R3

  AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req); // R3

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_issue |=> (pc_o == ($past(pc_o) + 1'b1))); // R2

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> (halted_o && !mem_req)); // R7

  AST_INT_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    int_entry |=> (mem_req && mem_we && (mem_addr == SAVE_ADDR) && !ie_o)); // R9

  AST_INT_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    int_entry |-> ie_o); // R8

endmodule

bind icyc_ctrl icyc_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .SAVE_ADDR (SAVE_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .pc_o        (pc_o),
  .ie_o        (ie_o),
  .halted_o    (halted_o),
  .int_entry   (int_entry),
  .fetch_issue (fetch_issue)
);

// File: tb/tb_icyc_ctrl.sv
`timescale 1ns/1ps
module tb_icyc_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic        mem_req, mem_we;
  logic [11:0] mem_addr, pc_o;
  logic [15:0] mem_wdata, acc_o;
  logic        ie_o, halted_o;

  always #2 clk = ~clk;

  icyc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .acc_o(acc_o),
    .pc_o(pc_o), .ie_o(ie_o), .halted_o(halted_o)
  );

  typedef struct {
    bit          we;
    logic [11:0] a;
    logic [15:0] d;
    string       tag;
  } xact_t;

  xact_t       exp_q[$];
  logic [15:0] mem [256];
  int          lat = 0;
  int          wait_cnt = 0;
  int          compared = 0;
  int          mismatched = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(bit we, logic [11:0] a, logic [15:0] d, string tag);
    xact_t x;
    x.we = we; x.a = a; x.d = d; x.tag = tag;
    exp_q.push_back(x);
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      wait_cnt  = 0;
    end else if (mem_req) begin
      if (wait_cnt >= lat) begin
        xact_t x;
        mem_ready = 1'b1;
        mem_rdata = mem[mem_addr[7:0]];
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        wait_cnt = 0;
        if (exp_q.size() == 0) begin
          chk("R3", {19'd0, mem_we, mem_addr}, 32'hFFFF_FFFF, "unexpected access");
        end else begin
          x = exp_q.pop_front();
          chk(x.tag, {19'd0, mem_we, mem_addr}, {19'd0, x.we, x.a}, "access kind/address");
          if (x.we) chk(x.tag, {16'd0, mem_wdata}, {16'd0, x.d}, "write data");
        end
      end else begin
        mem_ready = 1'b0;
        wait_cnt++;
      end
    end else begin
      mem_ready = 1'b0;
      wait_cnt  = 0;
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    exp_q.delete();
  endtask

  task automatic start_case(int l, logic irq_lvl);
    rst_n = 1'b0;
    lat   = l;
    irq   = irq_lvl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_case(string name);
    int n = 0;
    while (!halted_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!halted_o) begin
      compared++;
      mismatched++;
      $display("FAIL R7 watchdog in case %s: actual running expected halted", name);
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R7", {31'd0, mem_req}, 32'd0, "request after halt");
    end
    chk("R2", exp_q.size(), 32'd0, "expected accesses left over");
  endtask

  initial begin
    // ---- reset state (R1)
    clear_mem();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", {20'd0, pc_o}, 32'd0, "pc in reset");
    chk("R1", {16'd0, acc_o}, 32'd0, "acc in reset");
    chk("R1", {31'd0, ie_o}, 32'd0, "ie in reset");
    chk("R1", {31'd0, mem_req}, 32'd0, "req in reset");
    chk("R1", {31'd0, halted_o}, 32'd0, "halted in reset");

    // ---- case A: direct load/add/store, zero wait (R2 R5 R3)
    clear_mem();
    mem[8'h00] = 16'h2040; mem[8'h01] = 16'h4041;
    mem[8'h02] = 16'h6042; mem[8'h03] = 16'hE000;
    mem[8'h40] = 16'h1234; mem[8'h41] = 16'hF00F;
    push(0, 12'h000, 16'h2040, "R2"); push(0, 12'h040, 16'h1234, "R5");
    push(0, 12'h001, 16'h4041, "R2"); push(0, 12'h041, 16'hF00F, "R5");
    push(0, 12'h002, 16'h6042, "R2"); push(1, 12'h042, 16'h0243, "R5");
    push(0, 12'h003, 16'hE000, "R7");
    start_case(0, 1'b0);
    finish_case("A");
    chk("R5", {16'd0, acc_o}, 32'h0243, "acc after add wrap");
    chk("R5", {16'd0, mem[8'h42]}, 32'h0243, "stored word");
    chk("R2", {20'd0, pc_o}, 32'h004, "pc after four fetches");
    chk("R7", {31'd0, halted_o}, 32'd1, "halted");

    // ---- case B: indirect operands and jump, two wait cycles (R4 R6 R3)
    clear_mem();
    mem[8'h00] = 16'h3050; mem[8'h01] = 16'h8005;
    mem[8'h05] = 16'h5051; mem[8'h06] = 16'h7052; mem[8'h07] = 16'hE000;
    mem[8'h50] = 16'h0060; mem[8'h51] = 16'h0061; mem[8'h52] = 16'h0062;
    mem[8'h60] = 16'h0007; mem[8'h61] = 16'h0003;
    push(0, 12'h000, 16'h3050, "R2"); push(0, 12'h050, 16'h0060, "R4");
    push(0, 12'h060, 16'h0007, "R4"); push(0, 12'h001, 16'h8005, "R2");
    push(0, 12'h005, 16'h5051, "R6"); push(0, 12'h051, 16'h0061, "R4");
    push(0, 12'h061, 16'h0003, "R4"); push(0, 12'h006, 16'h7052, "R2");
    push(0, 12'h052, 16'h0062, "R4"); push(1, 12'h062, 16'h000A, "R4");
    push(0, 12'h007, 16'hE000, "R3");
    start_case(2, 1'b0);
    finish_case("B");
    chk("R4", {16'd0, acc_o}, 32'h000A, "acc via indirect");
    chk("R6", {20'd0, pc_o}, 32'h008, "pc after jump path");

    // ---- case C: irq held from reset; ignored while disabled, taken after enable (R8 R9)
    clear_mem();
    mem[8'h00] = 16'h0000; mem[8'h01] = 16'hA000;
    mem[8'h02] = 16'h0000; mem[8'h03] = 16'hE000;
    mem[8'h80] = 16'h2044; mem[8'h81] = 16'hE000; mem[8'h44] = 16'h5A5A;
    push(0, 12'h000, 16'h0000, "R8"); push(0, 12'h001, 16'hA000, "R8");
    push(1, 12'h0F0, 16'h0002, "R9"); push(0, 12'h080, 16'h2044, "R9");
    push(0, 12'h044, 16'h5A5A, "R9"); push(0, 12'h081, 16'hE000, "R9");
    start_case(1, 1'b1);
    finish_case("C");
    chk("R9", {31'd0, ie_o}, 32'd0, "ie cleared by entry");
    chk("R9", {16'd0, mem[8'hF0]}, 32'h0002, "saved pc word");
    chk("R9", {16'd0, acc_o}, 32'h5A5A, "handler ran");
    chk("R9", {20'd0, pc_o}, 32'h082, "pc in handler");
    irq = 1'b0;

    // ---- case D: irq pulse inside an instruction is not taken (R10 R7)
    clear_mem();
    mem[8'h00] = 16'hA000; mem[8'h01] = 16'h2045;
    mem[8'h02] = 16'hC000; mem[8'h03] = 16'hE000; mem[8'h45] = 16'h1357;
    push(0, 12'h000, 16'hA000, "R7");  push(0, 12'h001, 16'h2045, "R10");
    push(0, 12'h045, 16'h1357, "R10"); push(0, 12'h002, 16'hC000, "R10");
    push(0, 12'h003, 16'hE000, "R7");
    start_case(3, 1'b0);
    fork
      begin
        do @(negedge clk); while (!(mem_req && !mem_we && mem_addr == 12'h001));
        irq = 1'b1;
        do @(negedge clk); while (!(mem_req && mem_addr == 12'h045));
        irq = 1'b0;
      end
    join_none
    finish_case("D");
    chk("R10", {16'd0, acc_o}, 32'h1357, "acc with no interrupt");
    chk("R10", {16'd0, mem[8'hF0]}, 32'h0000, "save word untouched");
    chk("R7", {31'd0, ie_o}, 32'd0, "ie cleared by disable opcode");
    chk("R10", {20'd0, pc_o}, 32'h004, "pc sequential");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #800000;
    mismatched++;
    compared++;
    $display("FAIL R7 global watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule